// File: doc/BRIEF.md
# Tearing-Effect Gated Long-Packet Frame Sender

This block pushes one frame of pixel bytes towards a command-mode display. The frame is cut into long write packets. Software loads a 32-bit packet header, then arms the transfer by writing a 24-bit byte budget together with an enable bit. It then asks for two bus turnarounds. The first turnaround hands the bus to the display. After the second one completes, a tearing-effect (TE) event from the display starts the frame.

Each packet on the byte output is made of the four header bytes, lowest byte first, then one command byte, then pixel payload bytes. Pixel payload bytes come from a valid/ready input stream. The length field of the header counts the command byte as well as the payload, so the budget for a frame of N lines is N times that field. The block counts the budget down one byte for every command or payload byte it sends. When the count reaches zero it drops the enable bit without help from software, and it goes back to waiting for a new arm, two new turnarounds and a new TE event.

A small register file holds the header, the budget and enable, the turnaround request together with two FIFO condition flags, and two write-1-to-clear event flags. Every register ignores writes that do not set all four byte enables.

Top module: `te_frame_sender`

## Requirements
- R1: After reset every register reads 0, `tx_valid`, `tx_last`, `px_ready` and `ta_req` are 0.
- R2: A register write whose byte enable is not 4'hF changes nothing. A write to the transfer register (address 0) while the enable bit is set is ignored. An arm write with a zero budget leaves the enable bit at 0.
- R3: Writing 1 to bit 6 of the control register (address 2) sets the turnaround request, seen on `ta_req` and on bit 6 of the register. The request clears itself on `ta_done`. A request written while one is still pending is ignored and does not add a turnaround.
- R4: The status register (address 3) sets bit 5 on every completed turnaround and bit 2 on every packet end. Writing 1 to a bit clears it.
- R5: `te_evt` starts the frame only when the enable bit is set and two turnarounds have completed since the last frame ended. In any other state it has no effect and `tx_valid` stays 0.
- R6: Every packet emits the header bytes in the order header[7:0], [15:8], [23:16], [31:24]. The command byte `CMD_BYTE` follows, then payload bytes taken from `px_data`. `tx_last` marks the final byte of each packet, and `tx_data` holds still while the output is stalled.
- R7: The packet length L is header[23:8] and includes the command byte (L=0 is treated as 1). Bits 23:0 of address 0 read the remaining budget, which drops by one per command or payload byte and never below zero.
- R8: `px_ready` is 1 only during the payload phase of a packet, which needs the enable bit, the TE event and a nonzero remaining budget.
- R9: When the budget is not a multiple of L, the last packet carries only the remaining bytes, counting its command byte.
- R10: When the budget reaches zero, bit 30 of address 0 reads 0 and the block returns to idle.
- R11: Address 2 reads `rx_fifo_nonempty` at bit 20 and `tx_fifo_full` at bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 transfer, 1 header, 2 control, 3 status) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables; writes apply only when all are set |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ta_req | output | 1 | Turnaround request to the lane logic |
| ta_done | input | 1 | Turnaround completed pulse |
| te_evt | input | 1 | Tearing-effect event pulse |
| tx_fifo_full | input | 1 | Transmit FIFO full flag |
| rx_fifo_nonempty | input | 1 | Receive FIFO not empty flag |
| px_valid | input | 1 | Pixel byte valid |
| px_data | input | 8 | Pixel byte |
| px_ready | output | 1 | Pixel byte accepted |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Output byte taken |

## Verification
The case hardest to reach from the ports is a TE event that arrives after only one turnaround. The run has to reach it after a duplicate request was written while the first turnaround was still pending, since that duplicate must not count. Each frame therefore writes the request twice before completing it once, then pulses `te_evt` and checks that no byte appears. Only after a second real turnaround does a TE event start the frame. The frames themselves use random lengths and budgets, some of them truncated, together with random stalls on both streams. The sent bytes are compared against a packet sequence that the bench builds from the budget and the length.

// File: rtl/te_fs_pkg.sv
package te_fs_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_HDR, PS_CMD, PS_PAY} pk_state_t;

  localparam logic [1:0] A_XFER = 2'd0;
  localparam logic [1:0] A_HDR  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  // Bytes in the next packet: the length field (command byte included,
  // zero treated as one), cut to what is left of the budget.
  function automatic logic [23:0] pkt_chunk(input logic [15:0] len, input logic [23:0] rem);
    logic [23:0] l;
    l = (len == 16'd0) ? 24'd1 : {8'd0, len};
    return (l < rem) ? l : rem;
  endfunction
endpackage

// File: rtl/te_fs_bta.sv
module te_fs_bta (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic ta_done,
  input  logic te_evt,
  input  logic armed,
  input  logic frame_done,
  output logic ta_req,
  output logic ta_cmpl,
  output logic te_seen
);
  logic [1:0] ta_cnt;
  logic       te_ok;

  assign ta_cmpl = ta_req && ta_done;
  assign te_ok   = te_evt && armed && (ta_cnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_req  <= 1'b0;
      ta_cnt  <= 2'd0;
      te_seen <= 1'b0;
    end else begin
      if (ta_cmpl)               ta_req <= 1'b0;
      else if (req_set)          ta_req <= 1'b1;
      if (frame_done)            ta_cnt <= 2'd0;
      else if (ta_cmpl && ta_cnt != 2'd2) ta_cnt <= ta_cnt + 2'd1;
      if (frame_done)            te_seen <= 1'b0;
      else if (te_ok)            te_seen <= 1'b1;
    end
  end

  p_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ta_req && ta_done |=> !ta_req);
  p_te_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_seen) |-> $past(armed) && $past(te_evt));
endmodule

// File: rtl/te_fs_pktz.sv
module te_fs_pktz
  import te_fs_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter logic [7:0] CMD_BYTE = 8'h2C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] rem,
  input  logic [15:0]      len,
  input  logic [31:0]      hdr,
  input  logic             px_valid,
  input  logic [7:0]       px_data,
  output logic             px_ready,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             byte_take,
  output logic             pkt_done,
  output logic             frame_done
);
  pk_state_t        st;
  logic [1:0]       hidx;
  logic [CNT_W-1:0] left;

  always_comb begin
    tx_valid  = 1'b0;
    tx_data   = 8'h00;
    tx_last   = 1'b0;
    px_ready  = 1'b0;
    byte_take = 1'b0;
    unique case (st)
      PS_HDR: begin
        tx_valid = 1'b1;
        tx_data  = hdr[8*hidx +: 8];
      end
      PS_CMD: begin
        tx_valid  = 1'b1;
        tx_data   = CMD_BYTE;
        tx_last   = (left == 1);
        byte_take = tx_ready;
      end
      PS_PAY: begin
        tx_valid  = px_valid;
        tx_data   = px_data;
        tx_last   = px_valid && (left == 1);
        px_ready  = tx_ready;
        byte_take = px_valid && tx_ready;
      end
      default: ;
    endcase
    pkt_done   = byte_take && (left == 1);
    frame_done = pkt_done && (rem == 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= PS_IDLE;
      hidx <= 2'd0;
      left <= '0;
    end else begin
      unique case (st)
        PS_IDLE: if (go && rem != 0) begin
          st   <= PS_HDR;
          hidx <= 2'd0;
          left <= pkt_chunk(len, rem);
        end
        PS_HDR: if (tx_ready) begin
          if (hidx == 2'd3) st <= PS_CMD;
          hidx <= hidx + 2'd1;
        end
        default: if (byte_take) begin
          left <= left - 1'b1;
          if (st == PS_CMD) st <= PS_PAY;
          if (pkt_done) begin
            hidx <= 2'd0;
            if (frame_done) st <= PS_IDLE;
            else begin
              st   <= PS_HDR;
              left <= pkt_chunk(len, rem - 1'b1);
            end
          end
        end
      endcase
    end
  end

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  p_hold_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_HDR) && !tx_ready |=> $stable(tx_data));
endmodule

// File: rtl/te_frame_sender.sv
module te_frame_sender
  import te_fs_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter logic [7:0] CMD_BYTE = 8'h2C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_be,
  output logic [31:0] reg_rdata,
  output logic        ta_req,
  input  logic        ta_done,
  input  logic        te_evt,
  input  logic        tx_fifo_full,
  input  logic        rx_fifo_nonempty,
  input  logic        px_valid,
  input  logic [7:0]  px_data,
  output logic        px_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int PAD_W = 30 - CNT_W;

  logic             wr_ok;
  logic             armed;
  logic [CNT_W-1:0] rem;
  logic [31:0]      hdr;
  logic             sent_f, ta_f;
  logic             ta_cmpl, te_seen;
  logic             byte_take, pkt_done, frame_done;
  logic             req_set;

  assign wr_ok   = reg_wr && (reg_be == 4'hF);
  assign req_set = wr_ok && (reg_addr == A_CTRL) && reg_wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      rem    <= '0;
      hdr    <= '0;
      sent_f <= 1'b0;
      ta_f   <= 1'b0;
    end else begin
      if (wr_ok && reg_addr == A_XFER && !armed) begin
        rem   <= reg_wdata[CNT_W-1:0];
        armed <= reg_wdata[30] && (reg_wdata[CNT_W-1:0] != 0);
      end else begin
        if (byte_take)  rem   <= rem - 1'b1;
        if (frame_done) armed <= 1'b0;
      end
      if (wr_ok && reg_addr == A_HDR) hdr <= reg_wdata;
      sent_f <= (sent_f && !(wr_ok && reg_addr == A_STAT && reg_wdata[2])) || pkt_done;
      ta_f   <= (ta_f   && !(wr_ok && reg_addr == A_STAT && reg_wdata[5])) || ta_cmpl;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_XFER:  reg_rdata = {1'b0, armed, {PAD_W{1'b0}}, rem};
      A_HDR:   reg_rdata = hdr;
      A_CTRL:  reg_rdata = {11'd0, rx_fifo_nonempty, 3'd0, tx_fifo_full, 9'd0, ta_req, 6'd0};
      default: reg_rdata = {26'd0, ta_f, 2'd0, sent_f, 2'd0};
    endcase
  end

  te_fs_bta u_bta (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .ta_done(ta_done),
    .te_evt(te_evt), .armed(armed), .frame_done(frame_done),
    .ta_req(ta_req), .ta_cmpl(ta_cmpl), .te_seen(te_seen)
  );

  te_fs_pktz #(.CNT_W(CNT_W), .CMD_BYTE(CMD_BYTE)) u_pktz (
    .clk(clk), .rst_n(rst_n), .go(armed && te_seen), .rem(rem),
    .len(hdr[23:8]), .hdr(hdr), .px_valid(px_valid), .px_data(px_data),
    .px_ready(px_ready), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .byte_take(byte_take),
    .pkt_done(pkt_done), .frame_done(frame_done)
  );

  p_px_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |-> armed && te_seen && (rem != 0));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> rem != 0);
  p_arm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !armed);
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !te_seen |-> !tx_valid);
endmodule

// File: tb/te_frame_sender_bench.sv
`timescale 1ns/100ps
module te_frame_sender_bench;
  localparam logic [7:0] CMD = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0; logic [3:0] reg_be = 0;
  logic [31:0] reg_rdata;
  logic ta_req, ta_done = 0, te_evt = 0, tx_fifo_full = 0, rx_fifo_nonempty = 0;
  logic px_valid = 0; logic [7:0] px_data = 0; logic px_ready;
  logic tx_valid, tx_last, tx_ready = 0; logic [7:0] tx_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_d [0:1023];
  logic       exp_l [0:1023];

  always #2.5 clk = ~clk;

  te_frame_sender u_te_frame_sender (.*);

  function automatic logic [7:0] pix(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); ta_done = 1; @(negedge clk); ta_done = 0;
  endtask

  task automatic pulse_te_quiet(input string tag);
    bit seen = 0;
    @(negedge clk); te_evt = 1; @(negedge clk); te_evt = 0;
    repeat (6) begin @(negedge clk); #1; if (tx_valid) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  // Build the expected byte stream from budget and length.
  function automatic int build(input int size, input int len, input logic [31:0] h);
    int n = 0, rem = size, p = 0, l = (len == 0) ? 1 : len;
    while (rem > 0) begin
      int c = (l < rem) ? l : rem;
      for (int i = 0; i < 4; i++) begin exp_d[n] = h[8*i +: 8]; exp_l[n] = 0; n++; end
      exp_d[n] = CMD; exp_l[n] = (c == 1); n++;
      for (int i = 1; i < c; i++) begin exp_d[n] = pix(p); exp_l[n] = (i == c - 1); p++; n++; end
      rem -= c;
    end
    return n;
  endfunction

  task automatic run_frame(input int size, input int len);
    logic [31:0] h, r;
    int n, got = 0, bad = 0, pidx = 0, cyc = 0;
    h = (32'(len) << 8) | 32'h39;
    n = build(size, len, h);
    wr(2'd1, h);
    wr(2'd0, 32'h4000_0000 | 32'(size));
    rd(2'd0, r);
    chk(r == (32'h4000_0000 | 32'(size)), "R7 armed budget readback", r, 32'h4000_0000 | size);
    wr(2'd0, 32'h4000_0003);
    rd(2'd0, r);
    chk(r[23:0] == 24'(size), "R2 write while armed ignored", r[23:0], size);
    pulse_te_quiet("R5 TE before turnarounds");
    wr(2'd2, 32'h40);
    chk(ta_req == 1, "R3 request raised", ta_req, 1);
    wr(2'd2, 32'h40);
    pulse_done();
    rd(2'd2, r);
    chk(r[6] == 0 && ta_req == 0, "R3 request self-cleared", r[6], 0);
    rd(2'd3, r);
    chk(r[5] == 1, "R4 turnaround flag", r, 32'h20);
    wr(2'd3, 32'h20);
    rd(2'd3, r);
    chk(r[5] == 0, "R4 turnaround flag cleared", r, 0);
    pulse_te_quiet("R3 duplicate request not counted");
    wr(2'd2, 32'h40);
    pulse_done();
    @(negedge clk); te_evt = 1; @(negedge clk); te_evt = 0;
    reg_addr = 2'd0;
    while (cyc < 3000) begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      px_valid = ($urandom % 3) != 0;
      px_data  = pix(pidx);
      #1;
      if (px_valid && px_ready) pidx++;
      if (tx_valid && tx_ready) begin
        if (got < 1024 && (got >= n || tx_data !== exp_d[got] || tx_last !== exp_l[got])) begin
          if (bad == 0) $display("FAIL R6 byte %0d of frame size=%0d len=%0d actual=%0h/%0b expected=%0h/%0b",
                                 got, size, len, tx_data, tx_last, exp_d[got], exp_l[got]);
          bad++;
        end
        got++;
      end
      if (got >= n && reg_rdata[30] == 0) break;
      cyc++;
    end
    tx_ready = 0; px_valid = 0;
    checks++; if (bad != 0) fails++;
    chk(got == n, (size % ((len == 0) ? 1 : len) != 0) ? "R9 truncated frame byte count" : "R6 frame byte count", got, n);
    rd(2'd0, r);
    chk(r == 0, "R10 enable and budget cleared", r, 0);
    rd(2'd3, r);
    chk(r[2] == 1, "R4 packet flag", r, 4);
    wr(2'd3, 32'h24);
    rd(2'd3, r);
    chk(r == 0, "R4 flags cleared", r, 0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r == 0, "R1 register reset value", r, 0);
    end
    chk(!tx_valid && !px_ready && !ta_req && !tx_last, "R1 outputs idle", {tx_valid, px_ready, ta_req}, 0);
    wr(2'd1, 32'hDEAD_BEEF, 4'h3);
    rd(2'd1, r);
    chk(r == 0, "R2 partial byte-enable ignored", r, 0);
    wr(2'd0, 32'h4000_0000);
    rd(2'd0, r);
    chk(r == 0, "R2 zero budget does not arm", r, 0);
    tx_fifo_full = 1; rx_fifo_nonempty = 1;
    rd(2'd2, r);
    chk(r == 32'h0011_0000, "R11 FIFO flags", r, 32'h0011_0000);
    tx_fifo_full = 0; rx_fifo_nonempty = 0;
    rd(2'd2, r);
    chk(r == 0, "R11 FIFO flags low", r, 0);
    run_frame(12, 4);
    run_frame(10, 4);
    run_frame(5, 1);
    run_frame(3, 9);
    for (int i = 0; i < 5; i++) run_frame(1 + int'($urandom % 40), 1 + int'($urandom % 8));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule